// File: doc/BRIEF.md
# Periodic Split Queue Head Inactivation Control

This block holds the cached flags of one periodic queue head that reaches a full- or low-speed device through a transaction translator. Once per micro-frame, on an evaluation strobe, it checks the start-split and complete-split masks against the current micro-frame index. It then either asks the bus engine for a start-split or a complete-split, or retires the queue head by clearing its Active flag.

Software can ask for a clean stop by setting the inactivate flag. The block honours that request only at a split boundary, with the split state in DoStart. Any complete-splits still pending are finished first, and the transfer state is not written back when Active is cleared. Software restarts the queue head in three steps: set Halted, clear the inactivate flag, then set Active and clear Halted in one write. A software write port carries a per-flag write mask, so one write can change several flags. A write that touches both Active and the inactivate flag is refused.

Top module: `split_qh_ctl`

## Requirements
- R1: After reset, Active, Halted and inactivate flags are 0, the split state is DoStart (0), and all strobes and `swWrRej` are low.
- R2: While Active is 0, an evaluation strobe produces no strobe and no change of the split state.
- R3: While Halted is 1, an evaluation strobe produces no strobe and no flag or state change, even with the inactivate flag at 0.
- R4: With Active 1, Halted 0, state DoStart and the inactivate flag 1, an evaluation strobe pulses `activeClr` and clears Active one cycle later, whatever the S-mask holds; `startSplit` stays low.
- R5: The inactivation of R4 never raises `qtdWbReq`.
- R6: With Active 1, Halted 0, inactivate 0 and state DoStart, an evaluation strobe whose index selects a set S-mask bit pulses `startSplit` one cycle later and moves the state to DoComplete (1).
- R7: In DoComplete, an evaluation strobe whose index selects a set C-mask bit pulses `completeSplit`. If `completeOk` is also 1, it pulses `qtdWbReq` and returns the state to DoStart; otherwise the state stays DoComplete.
- R8: When the inactivate flag is set in DoComplete, complete-splits still issue, and Active is cleared on the first evaluation after the state is back in DoStart.
- R9: A software write updates, one cycle later, each flag whose mask bit is 1 to the matching data bit (bit 0 Active, bit 1 Halted, bit 2 inactivate). Setting Active and clearing Halted in one write is allowed.
- R10: A write whose mask has both bit 0 and bit 2 set changes no flag and pulses `swWrRej` one cycle later.
- R11: Nothing happens without `frameTick`. Bit `uframeIdx` of each mask is the one used, and after index 7 the index wraps to 0.
- R12: When a software write and an evaluation fall in the same cycle, the decision uses the flags from before the write. A written flag takes the software value, and an Active clear from the evaluation takes effect only when the write does not touch Active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| frameTick | input | 1 | One-cycle evaluation strobe per micro-frame |
| uframeIdx | input | 3 | Current micro-frame index |
| sMask | input | 8 | Start-split micro-frame mask |
| cMask | input | 8 | Complete-split micro-frame mask |
| completeOk | input | 1 | The complete-split of this micro-frame finishes the split |
| swWrEn | input | 1 | Software flag write enable |
| swWrMask | input | 3 | Per-flag write mask (bit 0 Active, 1 Halted, 2 inactivate) |
| swWrData | input | 3 | Per-flag write data, same bit order |
| startSplit | output | 1 | Issue a start-split this micro-frame |
| completeSplit | output | 1 | Issue a complete-split this micro-frame |
| activeClr | output | 1 | Active-clear write-back to the queue head |
| qtdWbReq | output | 1 | Request to write transfer state back to the current qTD |
| swWrRej | output | 1 | The previous software write was refused |
| activeQ | output | 1 | Cached Active flag |
| haltedQ | output | 1 | Cached Halted flag |
| inactQ | output | 1 | Cached inactivate flag |
| splitState | output | 1 | Split state, 0 DoStart, 1 DoComplete |

## Verification
A wrong split state shows up at the next evaluation whose micro-frame selects a mask bit. The block then gives a start-split where a complete-split is due, or the reverse, or it retires the queue head in the middle of a split. A stuck or wrongly written flag shows on the flag outputs one cycle after the write. It also shows on the next evaluation, as a strobe that should have been blocked or a missing `activeClr`. The reference model therefore compares all outputs on every cycle, so a divergence is reported within one cycle of the edge that caused it.

// File: rtl/split_qh_pkg.sv
package split_qh_pkg;

  localparam int FLAG_W = 3;
  localparam int FLAG_ACTIVE = 0;
  localparam int FLAG_HALTED = 1;
  localparam int FLAG_INACT = 2;

  typedef enum logic {
    DO_START    = 1'b0,
    DO_COMPLETE = 1'b1
  } splitState_e;

  // Control-to-datapath strobes, valid in the cycle of the evaluation.
  typedef struct packed {
    logic clrActive;
    logic goComplete;
    logic goStart;
  } ctlStrobe_t;

endpackage

// File: rtl/split_qh_datapath.sv
module split_qh_datapath
  import split_qh_pkg::*;
#(
  parameter int UFRAMES = 8,
  localparam int IDX_W = $clog2(UFRAMES)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [IDX_W-1:0]   uframeIdx,
  input  logic [UFRAMES-1:0] sMask,
  input  logic [UFRAMES-1:0] cMask,
  input  logic               swWrEn,
  input  logic [FLAG_W-1:0]  swWrMask,
  input  logic [FLAG_W-1:0]  swWrData,
  input  ctlStrobe_t         ctl,
  output logic               sBit,
  output logic               cBit,
  output logic               activeQ,
  output logic               haltedQ,
  output logic               inactQ,
  output splitState_e        stateQ,
  output logic               swWrRej
);

  logic [UFRAMES-1:0] sHit;
  logic [UFRAMES-1:0] cHit;

  // Pick the mask bit of the current micro-frame.
  for (genvar g = 0; g < UFRAMES; g++) begin : g_sel
    assign sHit[g] = (uframeIdx == IDX_W'(g)) & sMask[g];
    assign cHit[g] = (uframeIdx == IDX_W'(g)) & cMask[g];
  end
  assign sBit = |sHit;
  assign cBit = |cHit;

  // Active and the inactivate flag may not change in one write.
  logic wrBad;
  logic wrOk;
  assign wrBad = swWrEn & swWrMask[FLAG_ACTIVE] & swWrMask[FLAG_INACT];
  assign wrOk  = swWrEn & ~wrBad;

  logic activeNext;
  logic haltedNext;
  logic inactNext;

  always_comb begin
    activeNext = activeQ;
    haltedNext = haltedQ;
    inactNext  = inactQ;
    if (ctl.clrActive) activeNext = 1'b0;
    if (wrOk) begin
      if (swWrMask[FLAG_ACTIVE]) activeNext = swWrData[FLAG_ACTIVE];
      if (swWrMask[FLAG_HALTED]) haltedNext = swWrData[FLAG_HALTED];
      if (swWrMask[FLAG_INACT])  inactNext  = swWrData[FLAG_INACT];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeQ <= 1'b0;
      haltedQ <= 1'b0;
      inactQ  <= 1'b0;
      swWrRej <= 1'b0;
    end else begin
      activeQ <= activeNext;
      haltedQ <= haltedNext;
      inactQ  <= inactNext;
      swWrRej <= wrBad;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= DO_START;
    end else if (ctl.goComplete) begin
      stateQ <= DO_COMPLETE;
    end else if (ctl.goStart) begin
      stateQ <= DO_START;
    end
  end

  // R10: a refused write leaves the inactivate flag untouched.
  p_reject_keeps_inact_r10: assert property (@(posedge clk) disable iff (!rstN)
    wrBad |=> inactQ == $past(inactQ));

  // R4: an Active clear not overridden by software lands.
  p_clear_lands_r4: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.clrActive && !(swWrEn && swWrMask[FLAG_ACTIVE])) |=> !activeQ);

  // R2: the split state never moves while Active is low and no write raises it.
  p_idle_state_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!activeQ && !swWrEn) |=> stateQ == $past(stateQ));

endmodule

// File: rtl/split_qh_control.sv
module split_qh_control
  import split_qh_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        frameTick,
  input  logic        completeOk,
  input  logic        sBit,
  input  logic        cBit,
  input  logic        activeQ,
  input  logic        haltedQ,
  input  logic        inactQ,
  input  splitState_e stateQ,
  output ctlStrobe_t  ctl,
  output logic        startSplit,
  output logic        completeSplit,
  output logic        activeClr,
  output logic        qtdWbReq
);

  logic evalGo;
  logic doStartSplit;
  logic doCompSplit;
  logic doRetire;
  logic doFinish;

  // Halted or inactive queue heads are never advanced.
  assign evalGo       = frameTick & activeQ & ~haltedQ;
  assign doRetire     = evalGo & (stateQ == DO_START) & inactQ;
  assign doStartSplit = evalGo & (stateQ == DO_START) & ~inactQ & sBit;
  assign doCompSplit  = evalGo & (stateQ == DO_COMPLETE) & cBit;
  assign doFinish     = doCompSplit & completeOk;

  always_comb begin
    ctl            = '0;
    ctl.clrActive  = doRetire;
    ctl.goComplete = doStartSplit;
    ctl.goStart    = doFinish;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startSplit    <= 1'b0;
      completeSplit <= 1'b0;
      activeClr     <= 1'b0;
      qtdWbReq      <= 1'b0;
    end else begin
      startSplit    <= doStartSplit;
      completeSplit <= doCompSplit;
      activeClr     <= doRetire;
      qtdWbReq      <= doFinish;
    end
  end

  // R3: no strobe follows an evaluation of a halted or inactive head.
  p_no_issue_halted_r3: assert property (@(posedge clk) disable iff (!rstN)
    (startSplit || completeSplit || activeClr) |-> $past(activeQ && !haltedQ));

  // R4: a start-split is never issued with the inactivate flag set.
  p_no_start_inact_r4: assert property (@(posedge clk) disable iff (!rstN)
    startSplit |-> $past(!inactQ));

  // R5: retiring the head never requests a qTD write-back.
  p_clr_no_wb_r5: assert property (@(posedge clk) disable iff (!rstN)
    activeClr |-> !qtdWbReq);

  // R7: complete-splits only come out of DoComplete.
  p_complete_from_state_r7: assert property (@(posedge clk) disable iff (!rstN)
    completeSplit |-> $past(stateQ == DO_COMPLETE));

  // R11: every strobe follows an evaluation strobe.
  p_tick_only_r11: assert property (@(posedge clk) disable iff (!rstN)
    (startSplit || completeSplit || activeClr || qtdWbReq) |-> $past(frameTick));

endmodule

// File: rtl/split_qh_ctl.sv
module split_qh_ctl
  import split_qh_pkg::*;
#(
  parameter int UFRAMES = 8,
  localparam int IDX_W = $clog2(UFRAMES)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               frameTick,
  input  logic [IDX_W-1:0]   uframeIdx,
  input  logic [UFRAMES-1:0] sMask,
  input  logic [UFRAMES-1:0] cMask,
  input  logic               completeOk,
  input  logic               swWrEn,
  input  logic [2:0]         swWrMask,
  input  logic [2:0]         swWrData,
  output logic               startSplit,
  output logic               completeSplit,
  output logic               activeClr,
  output logic               qtdWbReq,
  output logic               swWrRej,
  output logic               activeQ,
  output logic               haltedQ,
  output logic               inactQ,
  output logic               splitState
);

  ctlStrobe_t  ctl;
  logic        sBit;
  logic        cBit;
  splitState_e stateQ;

  split_qh_datapath #(.UFRAMES(UFRAMES)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .uframeIdx(uframeIdx),
    .sMask    (sMask),
    .cMask    (cMask),
    .swWrEn   (swWrEn),
    .swWrMask (swWrMask),
    .swWrData (swWrData),
    .ctl      (ctl),
    .sBit     (sBit),
    .cBit     (cBit),
    .activeQ  (activeQ),
    .haltedQ  (haltedQ),
    .inactQ   (inactQ),
    .stateQ   (stateQ),
    .swWrRej  (swWrRej)
  );

  split_qh_control u_ctl (
    .clk          (clk),
    .rstN         (rstN),
    .frameTick    (frameTick),
    .completeOk   (completeOk),
    .sBit         (sBit),
    .cBit         (cBit),
    .activeQ      (activeQ),
    .haltedQ      (haltedQ),
    .inactQ       (inactQ),
    .stateQ       (stateQ),
    .ctl          (ctl),
    .startSplit   (startSplit),
    .completeSplit(completeSplit),
    .activeClr    (activeClr),
    .qtdWbReq     (qtdWbReq)
  );

  assign splitState = stateQ;

endmodule

// File: tb/split_qh_ctl_test.sv
module split_qh_ctl_test;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic frameTick = 1'b0;
  logic [2:0] uframeIdx = '0;
  logic [7:0] sMask = '0;
  logic [7:0] cMask = '0;
  logic completeOk = 1'b0;
  logic swWrEn = 1'b0;
  logic [2:0] swWrMask = '0;
  logic [2:0] swWrData = '0;
  logic startSplit, completeSplit, activeClr, qtdWbReq, swWrRej;
  logic activeQ, haltedQ, inactQ, splitState;

  int nCmp = 0;
  int nBad = 0;

  always #10 clk = ~clk;

  split_qh_ctl uut (
    .clk(clk), .rstN(rstN), .frameTick(frameTick), .uframeIdx(uframeIdx),
    .sMask(sMask), .cMask(cMask), .completeOk(completeOk),
    .swWrEn(swWrEn), .swWrMask(swWrMask), .swWrData(swWrData),
    .startSplit(startSplit), .completeSplit(completeSplit),
    .activeClr(activeClr), .qtdWbReq(qtdWbReq), .swWrRej(swWrRej),
    .activeQ(activeQ), .haltedQ(haltedQ), .inactQ(inactQ),
    .splitState(splitState)
  );

  // Behavioural reference of the cached queue head.
  bit mA, mH, mI, mS, mStart, mComp, mClr, mWb, mRej;

  always @(posedge clk) begin
    bit nA, nH, nI, nS;
    if (!rstN) begin
      mA = 0; mH = 0; mI = 0; mS = 0;
      mStart = 0; mComp = 0; mClr = 0; mWb = 0; mRej = 0;
    end else begin
      nA = mA; nH = mH; nI = mI; nS = mS;
      mStart = 0; mComp = 0; mClr = 0; mWb = 0; mRej = 0;
      if (frameTick && mA && !mH) begin
        if (!mS) begin
          if (mI) begin mClr = 1; nA = 0; end
          else if (sMask[uframeIdx]) begin mStart = 1; nS = 1; end
        end else if (cMask[uframeIdx]) begin
          mComp = 1;
          if (completeOk) begin mWb = 1; nS = 0; end
        end
      end
      if (swWrEn) begin
        if (swWrMask[0] && swWrMask[2]) mRej = 1;
        else begin
          if (swWrMask[0]) nA = swWrData[0];
          if (swWrMask[1]) nH = swWrData[1];
          if (swWrMask[2]) nI = swWrData[2];
        end
      end
      mA = nA; mH = nH; mI = nI; mS = nS;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nCmp++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Compare every output against the model on every falling edge.
  always @(negedge clk) begin
    if (rstN) begin
      chk(startSplit == mStart, "R6 startSplit", startSplit, mStart);
      chk(completeSplit == mComp, "R7 completeSplit", completeSplit, mComp);
      chk(activeClr == mClr, "R4 activeClr", activeClr, mClr);
      chk(qtdWbReq == mWb, "R5 qtdWbReq", qtdWbReq, mWb);
      chk(swWrRej == mRej, "R10 swWrRej", swWrRej, mRej);
      chk(activeQ == mA, "R9 activeQ", activeQ, mA);
      chk(haltedQ == mH, "R9 haltedQ", haltedQ, mH);
      chk(inactQ == mI, "R9 inactQ", inactQ, mI);
      chk(splitState == mS, "R7 splitState", splitState, mS);
    end
  end

  // Inputs change on the falling edge; outputs are valid at the next one.
  task automatic tick(input int idx, input logic [7:0] s, input logic [7:0] c, input bit ok);
    uframeIdx = 3'(idx); sMask = s; cMask = c; completeOk = ok; frameTick = 1'b1;
    @(negedge clk);
    frameTick = 1'b0;
  endtask

  task automatic wr(input logic [2:0] m, input logic [2:0] d);
    swWrEn = 1'b1; swWrMask = m; swWrData = d;
    @(negedge clk);
    swWrEn = 1'b0;
  endtask

  initial begin
    #(20 * 100000);
    nBad++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    int cnt;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state
    chk({activeQ, haltedQ, inactQ, splitState} == 4'b0, "R1 flags", activeQ, 0);
    chk({startSplit, completeSplit, activeClr, qtdWbReq, swWrRej} == 5'b0, "R1 strobes", startSplit, 0);

    // R2: inactive head ignores evaluations
    cnt = 0;
    for (int i = 0; i < 8; i++) begin
      tick(i, 8'hFF, 8'hFF, 1'b1);
      cnt += int'(startSplit) + int'(completeSplit) + int'(activeClr);
    end
    chk(cnt == 0 && splitState == 1'b0, "R2 idle", cnt, 0);

    // R3: halted head ignores evaluations
    wr(3'b011, 3'b011);
    cnt = 0;
    for (int i = 0; i < 8; i++) begin
      tick(i, 8'hFF, 8'hFF, 1'b1);
      cnt += int'(startSplit) + int'(completeSplit) + int'(activeClr);
    end
    chk(cnt == 0 && activeQ && splitState == 1'b0, "R3 halted", cnt, 0);

    // R9: clear Halted; R6/R11: start at index 2 only
    wr(3'b010, 3'b000);
    chk(!haltedQ, "R9 halted cleared", haltedQ, 0);
    tick(0, 8'h04, 8'h30, 1'b0);
    chk(!startSplit, "R11 idx0", startSplit, 0);
    tick(1, 8'h04, 8'h30, 1'b0);
    tick(2, 8'h04, 8'h30, 1'b0);
    chk(startSplit && splitState, "R6 start idx2", startSplit, 1);
    tick(3, 8'h04, 8'h30, 1'b0);
    tick(4, 8'h04, 8'h30, 1'b0);
    chk(completeSplit && !qtdWbReq && splitState, "R7 incomplete", qtdWbReq, 0);
    tick(5, 8'h04, 8'h30, 1'b1);
    chk(completeSplit && qtdWbReq && !splitState, "R7 done", qtdWbReq, 1);

    // R11: wrap 7 -> 0 with S-mask bit 0
    tick(6, 8'h01, 8'h02, 1'b0);
    tick(7, 8'h01, 8'h02, 1'b0);
    chk(!startSplit, "R11 idx7", startSplit, 0);
    tick(0, 8'h01, 8'h02, 1'b0);
    chk(startSplit, "R11 wrap idx0", startSplit, 1);

    // R8: inactivate while DoComplete, completes still run
    wr(3'b100, 3'b100);
    tick(1, 8'h01, 8'h02, 1'b1);
    chk(completeSplit && activeQ && !splitState, "R8 complete runs", completeSplit, 1);
    tick(2, 8'hFF, 8'hFF, 1'b0);
    chk(activeClr && !activeQ && !startSplit && !qtdWbReq, "R8 retire", activeClr, 1);

    // R9: three-step reactivation
    wr(3'b010, 3'b010);
    wr(3'b100, 3'b000);
    wr(3'b011, 3'b001);
    chk(activeQ && !haltedQ && !inactQ, "R9 reactivate", activeQ, 1);

    // R10: Active and inactivate in one write are refused
    wr(3'b101, 3'b100);
    chk(swWrRej && activeQ && !inactQ, "R10 refuse", inactQ, 0);

    // R4/R5: inactivate in DoStart with every S-mask bit set
    wr(3'b100, 3'b100);
    tick(3, 8'hFF, 8'h00, 1'b1);
    chk(activeClr && !startSplit && !qtdWbReq && !activeQ, "R4 R5 retire", activeClr, 1);

    // R12: write Halted in the cycle the evaluation clears Active
    wr(3'b010, 3'b010);
    wr(3'b100, 3'b000);
    wr(3'b011, 3'b001);
    wr(3'b100, 3'b100);
    swWrEn = 1'b1; swWrMask = 3'b010; swWrData = 3'b010;
    tick(4, 8'h00, 8'h00, 1'b0);
    swWrEn = 1'b0;
    chk(activeClr && !activeQ && haltedQ, "R12 merge", activeQ, 0);
    // R12: a write to Active overrides the evaluation's clear
    wr(3'b010, 3'b000);
    chk(!activeQ, "R2 still inactive", activeQ, 0);
    wr(3'b001, 3'b001);
    swWrEn = 1'b1; swWrMask = 3'b001; swWrData = 3'b001;
    tick(5, 8'h00, 8'h00, 1'b0);
    swWrEn = 1'b0;
    chk(activeClr && activeQ, "R12 override", activeQ, 1);

    repeat (3) @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

endmodule